// File: doc/BRIEF.md
# Even-Step Sequence Counter

This block is a synchronous counter that visits only even codes. With the enable high, each rising clock edge moves the state two codes forward: 0, 2, 4, 6, 8, 10, 12, 14, and then back to 0. With the enable low, the state stays where it is. A synchronous, active-high reset loads a start value, and that value is a parameter.

The next state is built from separate per-bit equations, never from an adder. The low bit is always driven to zero. The bits above it form a binary count of half the value. A parameter selects between two next-state variants:
- a minimized sum-of-products form, written for the 4-bit width;
- a toggle-chain form that scales to any width.

If the register ever holds an odd code, the next enabled step clears the low bit and advances the upper bits by the same equations. The counter is therefore back on the even cycle after one step.

Top module: `even_step_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state after that edge is the parameter `INIT_VAL` (default 0), whatever `en` is.
- R2: With `rst` low and `en` low at a rising edge, `q` keeps its value across that edge.
- R3: With `rst` low and `en` high, an even state q becomes (q + 2) mod 2^W after the edge. For W = 4 the order is 0, 2, 4, 6, 8, 10, 12, 14, 0.
- R4: After every enabled step, bit 0 of `q` is 0.
- R5: After every enabled step, bit 1 of `q` is the inverse of its previous value.
- R6: After every enabled step, bit 2 of `q` equals the previous bit 2 XOR the previous bit 1.
- R7: For W = 4, after every enabled step, bit 3 equals Q3·Q1' + Q3·Q2' + Q3'·Q2·Q1 of the previous state.
- R8: From an odd state, one enabled step gives ((q with bit 0 cleared) + 2) mod 2^W, which is an even code.
- R9: From state 14 (W = 4), an enabled step gives 0. From 0, eight enabled steps return the counter to 0.
- R10: The toggle-chain variant and the sum-of-products variant give the same sequence at W = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `INIT_VAL` |
| en | input | 1 | Count enable; when low, the state holds |
| q | output | W | Current counter state |

## Verification
The in-module assertions check the following on every cycle: the reset value, hold with the enable low, the cleared low bit, and the per-bit relations for bits 1, 2 and the top bit. Each is checked against the previous state, so it covers every code the counter passes through.

Some behaviours can only be shown by the bench's scenarios:
- the arithmetic order of a full cycle, including the wrap from 14 to 0;
- recovery from each of the eight odd codes, which the bench reaches through instances with an odd reset value;
- agreement between the two next-state variants.

// File: rtl/even_ctr_pkg.sv
package even_ctr_pkg;

   // Selects how the next-state bits above bit 0 are formed
   typedef enum logic {
      NXT_CHAIN = 1'b0,   // toggle chain, any width
      NXT_SOP   = 1'b1    // minimized sum-of-products, 4-bit only
   } nxt_style_e;

   localparam int unsigned EVC_MIN_W = 2;
   localparam int unsigned EVC_SOP_W = 4;

endpackage

// File: rtl/even_next_logic.sv
module even_next_logic
   import even_ctr_pkg::*;
#(
   parameter int unsigned W     = 4,
   parameter nxt_style_e  STYLE = NXT_SOP
) (
   input  logic [W-1:1] q_cur,
   output logic [W-1:0] q_nxt
);

   // Bit 0 is forced low in every variant
   assign q_nxt[0] = 1'b0;

   generate
      if (STYLE == NXT_SOP) begin : g_sop
         if (W != EVC_SOP_W) begin : g_bad_w
            $error("even_next_logic: SOP variant needs W == %0d", EVC_SOP_W);
         end
         assign q_nxt[1] = ~q_cur[1];
         assign q_nxt[2] = (q_cur[2] & ~q_cur[1]) | (~q_cur[2] & q_cur[1]);
         assign q_nxt[3] = (q_cur[3] & ~q_cur[1])
                         | (q_cur[3] & ~q_cur[2])
                         | (~q_cur[3] & q_cur[2] & q_cur[1]);
      end else begin : g_chain
         // ch[k] is high when every bit below k (down to 1) is set
         logic [W-1:1] ch;
         assign ch[1] = 1'b1;
         for (genvar k = 1; k < W - 1; k++) begin : g_link
            assign ch[k+1] = ch[k] & q_cur[k];
         end
         for (genvar k = 1; k < W; k++) begin : g_bit
            assign q_nxt[k] = q_cur[k] ^ ch[k];
         end
      end
   endgenerate

endmodule

// File: rtl/even_state_reg.sv
module even_state_reg #(
   parameter int unsigned W        = 4,
   parameter int unsigned INIT_VAL = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] RST_CODE = INIT_VAL[W-1:0];

   always_ff @(posedge clk) begin
      if (rst)     q <= RST_CODE;
      else if (en) q <= d;
   end

   // R1
   // reset_load_chk
   reset_load_chk: assert property (@(posedge clk) rst |=> q == RST_CODE);

   // R2
   // hold_chk
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(q));

endmodule

// File: rtl/even_step_counter.sv
module even_step_counter
   import even_ctr_pkg::*;
#(
   parameter int unsigned W        = 4,
   parameter int unsigned INIT_VAL = 0,
   parameter nxt_style_e  STYLE    = NXT_SOP
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   output logic [W-1:0] q
);

   localparam longint unsigned CODE_SPAN = 64'd1 << W;

   generate
      if (W < EVC_MIN_W) begin : g_bad_w
         $error("even_step_counter: W must be at least %0d", EVC_MIN_W);
      end
      if (INIT_VAL >= CODE_SPAN) begin : g_bad_init
         $error("even_step_counter: INIT_VAL does not fit in W bits");
      end
   endgenerate

   logic [W-1:0] nxt;

   even_next_logic #(.W(W), .STYLE(STYLE)) u_next (
      .q_cur (q[W-1:1]),
      .q_nxt (nxt)
   );

   even_state_reg #(.W(W), .INIT_VAL(INIT_VAL)) u_reg (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .d   (nxt),
      .q   (q)
   );

   // R4
   // low_bit_clear_chk
   low_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
      en |=> q[0] == 1'b0);

   // R5
   // bit1_toggle_chk
   bit1_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      en |=> q[1] != $past(q[1]));

   generate
      if (W >= 3) begin : g_upper_chk
         // R6
         // bit2_step_chk
         bit2_step_chk: assert property (@(posedge clk) disable iff (rst)
            en |=> q[2] == $past(q[2] ^ q[1]));
         // R7
         // top_bit_step_chk
         top_bit_step_chk: assert property (@(posedge clk) disable iff (rst)
            en |=> q[W-1] == $past(q[W-1] ^ (&q[W-2:1])));
      end
   endgenerate

endmodule

// File: tb/even_step_counter_bench.sv
module even_step_counter_bench;
   import even_ctr_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en  = 1'b0;
   logic [W-1:0] q;
   logic [W-1:0] q_chain;
   logic [W-1:0] q_odd [8];

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   even_step_counter #(.W(W), .INIT_VAL(0), .STYLE(NXT_SOP)) u_even_step_counter (
      .clk(clk), .rst(rst), .en(en), .q(q));

   even_step_counter #(.W(W), .INIT_VAL(0), .STYLE(NXT_CHAIN)) u_chain (
      .clk(clk), .rst(rst), .en(en), .q(q_chain));

   for (genvar j = 0; j < 8; j++) begin : g_odd
      even_step_counter #(.W(W), .INIT_VAL(2*j+1), .STYLE(NXT_SOP)) u_odd (
         .clk(clk), .rst(rst), .en(en), .q(q_odd[j]));
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
   end

   initial begin
      int prev;
      int exp;
      int b3;
      // R1: reset loads INIT_VAL
      repeat (3) @(negedge clk);
      chk("R1 reset", int'(q), 0);
      for (int j = 0; j < 8; j++) chk("R1 odd reset", int'(q_odd[j]), 2*j+1);

      rst = 1'b0;
      en  = 1'b1;
      exp = 0;
      for (int s = 0; s < 20; s++) begin
         prev = exp;
         @(negedge clk);
         exp = (prev + 2) % 16;
         chk("R3 step", int'(q), exp);
         chk("R4 bit0", int'(q[0]), 0);
         chk("R5 bit1", int'(q[1]), 1 - ((prev >> 1) & 1));
         chk("R6 bit2", int'(q[2]), ((prev >> 2) & 1) ^ ((prev >> 1) & 1));
         b3 = (((prev >> 3) & 1) & ~((prev >> 1) & 1))
            | (((prev >> 3) & 1) & ~((prev >> 2) & 1))
            | (~((prev >> 3) & 1) & ((prev >> 2) & 1) & ((prev >> 1) & 1));
         chk("R7 bit3", int'(q[3]), b3 & 1);
         chk("R10 chain", int'(q_chain), exp);
         if (prev == 14) chk("R9 wrap", int'(q), 0);
         if (s == 0) begin
            // R8: each odd start rejoins the even cycle in one step
            for (int j = 0; j < 8; j++)
               chk("R8 odd recover", int'(q_odd[j]), (((2*j+1) & ~1) + 2) % 16);
         end
      end

      // R2: hold with enable low
      en = 1'b0;
      prev = int'(q);
      repeat (5) begin
         @(negedge clk);
         chk("R2 hold", int'(q), prev);
         chk("R2 hold chain", int'(q_chain), prev);
      end

      // R1: reset wins over enable
      en  = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      chk("R1 reset over en", int'(q), 0);
      rst = 1'b0;

      // R9: eight steps from 0 return to 0
      repeat (8) @(negedge clk);
      chk("R9 full cycle", int'(q), 0);
      chk("R10 chain cycle", int'(q_chain), 0);

      summary();
   end

endmodule